// File: doc/BRIEF.md
# Converter Readout SPI Master

This block is the host side of a serial link to a converter that shares one pin between its serial data output and its "result ready" indication. On a start request the block pulls chip select low and watches the shared line. Once the line goes low, a fresh result is waiting, and the block clocks a frame of 16 or 32 bits. During that frame it shifts out the configuration word and shifts in the conversion result. In 32-bit mode the configuration word goes out twice. The second half of the received frame is the converter's echo of its configuration, and the block compares that echo with the word it sent.

The serial clock comes from the system clock through a programmable divider. Each finished frame becomes one beat on a valid/ready result port that carries the result, the echoed word, a mismatch flag and a timeout flag. The beat stays valid, and its payload does not change, until the consumer takes it with ready high. While a beat waits, chip select stays high and no new request is accepted. The 16-bit mode relies on chip select returning high between frames, and this block always raises chip select after each frame. The start bit of a single-shot conversion reads back differently from how it was written, so the comparison leaves that bit out.

Top module: `adc_readout_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0 and `m_valid` is 0.
- R2: A `start` pulse in idle drives `cs_n` low. No `sclk` edge occurs until `miso` has been seen low, and that check is made only from the third system cycle after chip select falls.
- R3: If `miso` has not been seen low when the wait counter reaches `tmo_limit` (which must be at least 2), `cs_n` stays low for exactly `tmo_limit`+1 system cycles. The block then delivers a beat with `m_timeout`=1 and with data, readback and mismatch all 0.
- R4: `sclk` idles low and is high only while `cs_n` is low. Each half period lasts `clk_div`+1 system cycles, with `clk_div` at least 2. A frame has 16 rising edges when `wide_mode`=0 and 32 when `wide_mode`=1.
- R5: `mosi` changes only at rising `sclk` edges and sends the most significant bit first. The frame carries `cfg_word` once in 16-bit mode and twice in a row in 32-bit mode.
- R6: Received bits are sampled at falling `sclk` edges, most significant bit first. The bit presented after the first rising edge is bit 15 of `m_data`, and `m_data` holds the first 16 received bits.
- R7: In 32-bit mode `m_readback` holds received bits 17 to 32. In 16-bit mode `m_readback` is 0.
- R8: In 32-bit mode `m_mismatch` is 1 exactly when `m_readback` and `cfg_word` differ in bits 14:0. A difference in bit 15 (the single-shot start bit) is ignored. In 16-bit mode `m_mismatch` is 0.
- R9: While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1, all payload outputs stay stable and `cs_n` stays high. The beat leaves on the first cycle in which `m_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one readout; accepted only in idle |
| wide_mode | input | 1 | 1: 32-bit frame with readback, 0: 16-bit frame |
| cfg_word | input | 16 | Configuration word to send |
| clk_div | input | DIV_W | Serial clock half period minus one, in system cycles |
| tmo_limit | input | TMO_W | Wait-for-ready limit in system cycles |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Shared serial data and ready line from the converter |
| m_valid | output | 1 | Result beat valid |
| m_ready | input | 1 | Consumer accepts the beat |
| m_data | output | 16 | Conversion result |
| m_readback | output | 16 | Echoed configuration (32-bit mode) |
| m_mismatch | output | 1 | Echo differs from the sent word outside the start bit |
| m_timeout | output | 1 | Ready never arrived within the limit |

## Verification
The assertions assume a configuration that holds still while a frame runs, a `clk_div` of at least 2 (so the two-stage synchronizer settles before a falling-edge sample) and a `tmo_limit` of at least 2. They also assume the converter only changes `miso` at rising `sclk` edges or chip-select changes. The bench's converter model drives the ready low and every data bit from rising serial clock edges. Its random choices keep `clk_div` between 2 and 5 and keep the ready delay well below the limit, except in the timeout case, where the model never signals ready.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_OUT
  } rd_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] readback;
    logic              mismatch;
    logic              timeout;
  } rd_result_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick = en && (cnt_q == div);
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
  assign sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4: serial clock returns low whenever the divider is off
  p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk);
  // R4: edges are at least one half period apart
  p_edge_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int FRAME_W = 32,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               rise,
  input  logic               fall,
  input  logic               sdi,
  output logic               sdo,
  output logic [FRAME_W-1:0] rx_word,
  output logic               done
);
  logic [FRAME_W-1:0] tx_q;
  logic [FRAME_W-1:0] rx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sdo_q;
  logic               done_q;
  logic               last;

  assign last    = fall && (cnt_q == (nbits - CNT_W'(1)));
  assign sdo     = sdo_q;
  assign rx_word = rx_q;
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        tx_q  <= tx_word;
        rx_q  <= '0;
        cnt_q <= '0;
        sdo_q <= 1'b0;
      end else begin
        if (rise) begin
          sdo_q <= tx_q[FRAME_W-1];
          tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
        end
        if (fall) begin
          rx_q  <= {rx_q[FRAME_W-2:0], sdi};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: outgoing data only moves at a rising serial edge
  p_mosi_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !load) |=> $stable(sdo));
  // R6: the frame never samples more bits than requested
  p_bit_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (cnt_q < nbits));
endmodule

// File: rtl/adc_readout_master.sv
module adc_readout_master
  import adc_rd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 16,
  parameter int SS_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_mode,
  input  logic [15:0]       cfg_word,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [15:0]       m_data,
  output logic [15:0]       m_readback,
  output logic              m_mismatch,
  output logic              m_timeout
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [WORD_W-1:0] CMP_MASK = ~(WORD_W'(1) << SS_BIT);

  rd_state_e          state_q;
  rd_result_t         res_q;
  logic [TMO_W-1:0]   tmo_cnt_q;
  logic [TMO_W-1:0]   lim_q;
  logic [DIV_W-1:0]   div_q;
  logic [WORD_W-1:0]  cfg_q;
  logic               wide_q;
  logic               miso_meta_q;
  logic               miso_s_q;
  logic               load;
  logic               xfer_en;
  logic               rise;
  logic               fall;
  logic               done;
  logic [FRAME_W-1:0] tx_word;
  logic [FRAME_W-1:0] rx_word;
  logic [CNT_W-1:0]   nbits;
  logic [WORD_W-1:0]  rx_data;
  logic [WORD_W-1:0]  rx_echo;
  logic               ready_seen;

  assign load       = (state_q == ST_IDLE) && start;
  assign xfer_en    = (state_q == ST_XFER);
  assign tx_word    = wide_mode ? {cfg_word, cfg_word} : {cfg_word, WORD_W'(0)};
  assign nbits      = wide_q ? CNT_W'(FRAME_W) : CNT_W'(WORD_W);
  assign ready_seen = (tmo_cnt_q >= TMO_W'(2)) && !miso_s_q;
  assign rx_data    = wide_q ? rx_word[FRAME_W-1:WORD_W] : rx_word[WORD_W-1:0];
  assign rx_echo    = wide_q ? rx_word[WORD_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_meta_q <= 1'b1;
      miso_s_q    <= 1'b1;
    end else begin
      miso_meta_q <= miso;
      miso_s_q    <= miso_meta_q;
    end
  end

  adc_rd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (xfer_en),
    .div  (div_q),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  adc_rd_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .tx_word(tx_word),
    .nbits  (nbits),
    .rise   (rise),
    .fall   (fall),
    .sdi    (miso_s_q),
    .sdo    (mosi),
    .rx_word(rx_word),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      res_q     <= '0;
      tmo_cnt_q <= '0;
      lim_q     <= '0;
      div_q     <= '0;
      cfg_q     <= '0;
      wide_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_WAIT;
            tmo_cnt_q <= '0;
            lim_q     <= tmo_limit;
            div_q     <= clk_div;
            cfg_q     <= cfg_word;
            wide_q    <= wide_mode;
          end
        end
        ST_WAIT: begin
          if (ready_seen) begin
            state_q <= ST_XFER;
          end else if (tmo_cnt_q == lim_q) begin
            state_q <= ST_OUT;
            res_q   <= '{data: '0, readback: '0, mismatch: 1'b0, timeout: 1'b1};
          end else begin
            tmo_cnt_q <= tmo_cnt_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (done) begin
            state_q <= ST_OUT;
            res_q   <= '{data: rx_data, readback: rx_echo,
                         mismatch: wide_q && (((rx_echo ^ cfg_q) & CMP_MASK) != '0),
                         timeout: 1'b0};
          end
        end
        ST_OUT: begin
          if (m_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n       = !((state_q == ST_WAIT) || (state_q == ST_XFER));
  assign m_valid    = (state_q == ST_OUT);
  assign m_data     = res_q.data;
  assign m_readback = res_q.readback;
  assign m_mismatch = res_q.mismatch;
  assign m_timeout  = res_q.timeout;

  // R4: serial clock only toggles with chip select low
  p_sclk_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R2: clocking begins only after the shared line was seen low
  p_xfer_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en) |-> !$past(miso_s_q));
  // R9: a stalled beat keeps its payload
  p_hold_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_readback)
                               && $stable(m_mismatch) && $stable(m_timeout)));
  // R9: no chip select activity while a beat is pending
  p_cs_idle_while_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> cs_n);
endmodule

// File: tb/tb_adc_readout_master.sv
`timescale 1ns/1ps
module tb_adc_readout_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [7:0]  clk_div = 8'd2;
  logic [15:0] tmo_limit = 16'd200;
  logic        cs_n, sclk, mosi;
  logic        miso;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_data, m_readback;
  logic        m_mismatch, m_timeout;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // converter model state
  logic [15:0] s_word = '0;
  logic [15:0] s_corrupt = '0;
  int          s_delay = 4;
  bit          s_never = 0;
  bit          s_wide = 0;
  int          s_rises = 0;
  logic [31:0] s_rx = '0;

  always #2.5 clk = ~clk;

  adc_readout_master dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .cfg_word(cfg_word), .clk_div(clk_div), .tmo_limit(tmo_limit),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_readback(m_readback), .m_mismatch(m_mismatch), .m_timeout(m_timeout)
  );

  always @(negedge sclk) s_rx <= {s_rx[30:0], mosi};

  initial begin
    logic [15:0] rb_w;
    rb_w = '0;
    miso = 1'b1;
    forever begin
      @(negedge cs_n);
      s_rises = 0;
      if (s_never) begin
        @(posedge cs_n);
      end else begin
        repeat (s_delay) @(posedge clk);
        miso = 1'b0;
        for (int b = 0; b < (s_wide ? 32 : 16); b++) begin
          @(posedge sclk or posedge cs_n);
          if (cs_n) break;
          s_rises++;
          if (b < 16) miso = s_word[15-b];
          else begin
            if (b == 16) rb_w = (s_rx[15:0] & 16'h7FFF) ^ s_corrupt;
            miso = rb_w[31-b];
          end
        end
        if (!cs_n) @(posedge cs_n);
      end
      miso = 1'b1;
    end
  end

  function automatic logic [15:0] exp_rb(bit wide, bit never, logic [15:0] cfg, logic [15:0] cor);
    return (wide && !never) ? ((cfg & 16'h7FFF) ^ cor) : 16'h0;
  endfunction

  function automatic logic exp_mis(bit wide, bit never, logic [15:0] cfg, logic [15:0] cor);
    return wide && !never && ((((cfg & 16'h7FFF) ^ cor) ^ cfg) & 16'h7FFF) != 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_txn(bit wide, logic [15:0] cfg, logic [15:0] word,
                         logic [15:0] cor, logic [7:0] div, int dly, bit never,
                         logic [15:0] lim, int hold);
    int cs_low;
    logic [15:0] d0, r0;
    logic mi0, to0;
    s_wide = wide; s_word = word; s_corrupt = cor; s_delay = dly; s_never = never;
    @(negedge clk);
    wide_mode = wide; cfg_word = cfg; clk_div = div; tmo_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cs_low = 0;
    while (!m_valid) begin
      if (!cs_n) cs_low++;
      @(negedge clk);
    end
    chk("R6 data", {16'h0, m_data}, {16'h0, never ? 16'h0 : word});
    chk("R7 readback", {16'h0, m_readback}, {16'h0, exp_rb(wide, never, cfg, cor)});
    chk("R8 mismatch", {31'h0, m_mismatch}, {31'h0, exp_mis(wide, never, cfg, cor)});
    chk("R3 timeout flag", {31'h0, m_timeout}, {31'h0, never});
    if (never) chk("R3 wait length", cs_low, 32'(lim) + 1);
    else begin
      chk("R4 rising edges", s_rises, wide ? 32 : 16);
      if (wide) chk("R5 sent bits", s_rx, {cfg, cfg});
      else chk("R5 sent bits", {16'h0, s_rx[15:0]}, {16'h0, cfg});
    end
    d0 = m_data; r0 = m_readback; mi0 = m_mismatch; to0 = m_timeout;
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      chk("R9 held valid", {31'h0, m_valid}, 32'h1);
      chk("R9 held payload", {m_data, m_readback}, {d0, r0});
      chk("R9 held flags", {30'h0, m_mismatch, m_timeout}, {30'h0, mi0, to0});
      chk("R9 cs idle", {31'h0, cs_n}, 32'h1);
    end
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    chk("R9 beat taken", {31'h0, m_valid}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    #1;
    chk("R1 cs_n reset", {31'h0, cs_n}, 32'h1);
    chk("R1 sclk reset", {31'h0, sclk}, 32'h0);
    chk("R1 valid reset", {31'h0, m_valid}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle cs_n", {31'h0, cs_n}, 32'h1);
    // directed corner cases
    run_txn(1'b1, 16'h858B, 16'h1234, 16'h0000, 8'd2, 3, 1'b0, 16'd200, 0);
    run_txn(1'b1, 16'h858B, 16'hFEDC, 16'h8000, 8'd3, 5, 1'b0, 16'd200, 2); // R8 start bit ignored
    run_txn(1'b1, 16'h0001, 16'h8001, 16'h0001, 8'd2, 1, 1'b0, 16'd200, 1); // R8 lowest bit
    run_txn(1'b0, 16'hFFFF, 16'h7FFF, 16'h0000, 8'd4, 8, 1'b0, 16'd200, 3);
    run_txn(1'b1, 16'hA5A5, 16'h0000, 16'h0000, 8'd2, 1, 1'b1, 16'd40, 2);  // R3 timeout
    run_txn(1'b0, 16'h1111, 16'h5555, 16'h0000, 8'd2, 1, 1'b1, 16'd2, 0);   // R3 minimum limit
    run_txn(1'b1, 16'h4321, 16'hAAAA, 16'h4000, 8'd5, 150, 1'b0, 16'd160, 0); // late ready
    // random traffic
    for (int i = 0; i < 24; i++) begin
      bit w;
      logic [15:0] cor;
      w = $urandom_range(0, 1);
      cor = ($urandom_range(0, 2) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      run_txn(w, 16'($urandom), 16'($urandom), cor, 8'($urandom_range(2, 5)),
              $urandom_range(1, 60), 1'b0, 16'd200, $urandom_range(0, 4));
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule